// File: doc/BRIEF.md
# Wake-Up Signal Qualification Controller

This controller sits behind a wake-up receiver's demodulator and decides when a sleeping radio may be powered. It watches the demodulated wake-up waveform, measures the time between successive rising edges in clock cycles, and counts periods that fall inside an accepted window. Only after a programmable number of back-to-back accepted periods does it raise the radio enable. Once at least one period has been accepted, the window is widened by a programmable hysteresis margin on both sides, so that ordinary drift of the wake-up tone does not break a run. A single out-of-window period drops the run count to zero and restores the narrow window.

A cycle-count watchdog guards the sensing phase. It restarts whenever a period is accepted. If it runs out before the run completes, the controller falls back to hibernation and flags the event with a one-cycle pulse. The controller also picks the oscillator capacitance code from three configured values, one per operating mode, so the clock runs slowly while hibernating and faster while sensing or awake. The radio enable stays asserted until an explicit clear, after which the controller hibernates again.

Top module: `wuq_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (hibernate), `radio_en` and `fault_pulse` are 0, and `osc_cap` equals `cfg_cap_hib`.
- R2: `osc_cap` equals `cfg_cap_hib` when `mode` is 0, `cfg_cap_sense` when `mode` is 1 (sensing) and `cfg_cap_awake` when `mode` is 2 (awake).
- R3: In hibernation, a rising edge on `wake_in` moves `mode` to 1 on the third clock edge after the input changes (two synchronizer stages plus the state register). A period is the number of clock cycles between two consecutive rising edges.
- R4: In sensing, the controller moves to `mode` 2 and raises `radio_en` on the rising edge that brings the count of consecutive accepted periods to `cfg_need`. N accepted periods therefore take N+1 rising edges, counting the one that started sensing.
- R5: While the accepted count is zero, a period is accepted only if `cfg_per_lo` <= period <= `cfg_per_hi`.
- R6: While the accepted count is nonzero, a period is accepted if `cfg_per_lo - cfg_hyst` <= period <= `cfg_per_hi + cfg_hyst`, with the lower bound saturating at 0 and the upper bound at the largest count.
- R7: A rejected period clears the accepted count to zero, so the following period is judged against the window without hysteresis.
- R8: In sensing, a watchdog counts clock cycles since entry or since the last accepted period; rejected periods do not restart it. When it reaches `cfg_wd_limit`, the next clock edge returns `mode` to 0 and `fault_pulse` is high for exactly one cycle.
- R9: `radio_en` stays high, whatever `wake_in` does, until `radio_clr` is sampled high; on that edge the controller returns to `mode` 0 and `radio_en` falls.
- R10: `radio_clr` has no effect while `mode` is 0 or 1.
- R11: A `cfg_need` of 0 behaves like 1: the first accepted period after entering sensing raises `radio_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (from the tunable oscillator) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_in | input | 1 | Demodulated wake-up waveform, asynchronous |
| cfg_per_lo | input | PER_W | Lower period limit in clock cycles |
| cfg_per_hi | input | PER_W | Upper period limit in clock cycles |
| cfg_hyst | input | PER_W | Window widening applied once a run has started |
| cfg_need | input | CNT_W | Consecutive accepted periods required |
| cfg_wd_limit | input | WD_W | Watchdog limit in clock cycles |
| cfg_cap_hib | input | CAP_W | Oscillator code for hibernation |
| cfg_cap_sense | input | CAP_W | Oscillator code for sensing |
| cfg_cap_awake | input | CAP_W | Oscillator code for awake operation |
| radio_clr | input | 1 | Releases the radio and returns to hibernation |
| radio_en | output | 1 | Downstream radio enable |
| osc_cap | output | CAP_W | Oscillator capacitance code for the current mode |
| fault_pulse | output | 1 | One-cycle pulse on watchdog expiry |
| mode | output | 2 | 0 hibernate, 1 sensing, 2 awake |

## Verification
Every decision the controller takes on a rising edge of `wake_in` shows at the ports on the third clock edge after the input changes, so the bench drives the input on falling edges and keeps every gap between rising edges at four cycles or more. This lets it sample mode, enable and oscillator code right after each gap has been driven, once the edge that closed the previous gap has been judged. The entry test counts falling edges one at a time to pin the three-edge latency. The radio clear acts on the next edge, and the watchdog test counts cycles from the input change to find the single edge at `cfg_wd_limit` + 4 where hibernation and the fault pulse appear, and checks that the pulse is gone one cycle later.

// File: rtl/wuq_pkg.sv
package wuq_pkg;

  typedef enum logic [1:0] {
    WQ_HIB   = 2'd0,
    WQ_SENSE = 2'd1,
    WQ_AWAKE = 2'd2
  } wq_mode_t;

endpackage

// File: rtl/wuq_edge_sync.sv
module wuq_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  localparam int TAPS = SYNC_STAGES + 1;

  logic [TAPS-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[TAPS-2:0], din};
    end
  end

  assign rise = chain[TAPS-2] & ~chain[TAPS-1];

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/wuq_period_meter.sv
module wuq_period_meter #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic [PER_W-1:0] period
);

  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [PER_W-1:0] per_cnt;

  function automatic logic [PER_W-1:0] step_count(input logic [PER_W-1:0] c);
    if (c == PER_MAX) return c;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (rise) begin
      per_cnt <= {{(PER_W-1){1'b0}}, 1'b1};
    end else begin
      per_cnt <= step_count(per_cnt);
    end
  end

  assign period = per_cnt;

  // R3
  per_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (per_cnt == {{(PER_W-1){1'b0}}, 1'b1}));

  // R3
  per_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && per_cnt != PER_MAX) |=> (per_cnt == $past(per_cnt) + 1'b1));

endmodule

// File: rtl/wuq_window_check.sv
module wuq_window_check #(
  parameter int PER_W = 12
) (
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] lim_lo,
  input  logic [PER_W-1:0] lim_hi,
  input  logic [PER_W-1:0] margin,
  input  logic             widen,
  output logic             in_win,
  output logic [PER_W-1:0] eff_lo,
  output logic [PER_W-1:0] eff_hi
);

  function automatic logic [PER_W-1:0] floor_sub(input logic [PER_W-1:0] a,
                                                 input logic [PER_W-1:0] b);
    if (a > b) return a - b;
    return '0;
  endfunction

  function automatic logic [PER_W-1:0] ceil_add(input logic [PER_W-1:0] a,
                                                input logic [PER_W-1:0] b);
    logic [PER_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s[PER_W]) return '1;
    return s[PER_W-1:0];
  endfunction

  always_comb begin
    if (widen) begin
      eff_lo = floor_sub(lim_lo, margin);
      eff_hi = ceil_add(lim_hi, margin);
    end else begin
      eff_lo = lim_lo;
      eff_hi = lim_hi;
    end
    in_win = (period >= eff_lo) && (period <= eff_hi);
  end

  // R6
  always_comb begin
    window_order_chk: assert (!widen || (eff_lo <= lim_lo && eff_hi >= lim_hi));
  end

endmodule

// File: rtl/wuq_watchdog.sv
module wuq_watchdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            reload,
  input  logic [WD_W-1:0] limit,
  output logic            expire
);

  localparam logic [WD_W-1:0] WD_MAX = '1;

  logic [WD_W-1:0] wd_cnt;

  function automatic logic [WD_W-1:0] wd_step(input logic [WD_W-1:0] c);
    if (c == WD_MAX) return c;
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt <= '0;
    end else if (!run || reload) begin
      wd_cnt <= '0;
    end else begin
      wd_cnt <= wd_step(wd_cnt);
    end
  end

  assign expire = run && (wd_cnt >= limit);

  // R8
  wd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (wd_cnt == '0));

  // R8
  wd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (wd_cnt == '0));

endmodule

// File: rtl/wuq_ctrl.sv
module wuq_ctrl
  import wuq_pkg::*;
#(
  parameter int PER_W       = 12,
  parameter int CNT_W       = 6,
  parameter int WD_W        = 16,
  parameter int CAP_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_in,
  input  logic [PER_W-1:0] cfg_per_lo,
  input  logic [PER_W-1:0] cfg_per_hi,
  input  logic [PER_W-1:0] cfg_hyst,
  input  logic [CNT_W-1:0] cfg_need,
  input  logic [WD_W-1:0]  cfg_wd_limit,
  input  logic [CAP_W-1:0] cfg_cap_hib,
  input  logic [CAP_W-1:0] cfg_cap_sense,
  input  logic [CAP_W-1:0] cfg_cap_awake,
  input  logic             radio_clr,
  output logic             radio_en,
  output logic [CAP_W-1:0] osc_cap,
  output logic             fault_pulse,
  output logic [1:0]       mode
);

  localparam int RUN_W = CNT_W + 1;

  // named internal events
  wq_mode_t         state_q;
  wq_mode_t         state_d;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_d;
  logic             rise;
  logic [PER_W-1:0] period;
  logic             in_win;
  logic [PER_W-1:0] win_lo;
  logic [PER_W-1:0] win_hi;
  logic             sensing;
  logic             edge_ok;
  logic             edge_bad;
  logic             run_done;
  logic             wd_expire;
  logic             wd_trip;
  logic             hib_wake;
  logic             clr_hit;
  logic [CNT_W-1:0] need_eff;

  function automatic logic [CNT_W-1:0] clamp_need(input logic [CNT_W-1:0] n);
    if (n == '0) return {{(CNT_W-1){1'b0}}, 1'b1};
    return n;
  endfunction

  function automatic logic run_complete(input logic [CNT_W-1:0] acc,
                                        input logic [CNT_W-1:0] need);
    logic [RUN_W-1:0] nxt;
    nxt = {1'b0, acc} + {{CNT_W{1'b0}}, 1'b1};
    return nxt >= {1'b0, need};
  endfunction

  function automatic logic [CAP_W-1:0] cap_for(input wq_mode_t m,
                                               input logic [CAP_W-1:0] c_hib,
                                               input logic [CAP_W-1:0] c_sense,
                                               input logic [CAP_W-1:0] c_awake);
    case (m)
      WQ_SENSE: return c_sense;
      WQ_AWAKE: return c_awake;
      default:  return c_hib;
    endcase
  endfunction

  wuq_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (wake_in),
    .rise (rise)
  );

  wuq_period_meter #(
    .PER_W(PER_W)
  ) u_meter (
    .clk   (clk),
    .rst_n (rst_n),
    .rise  (rise),
    .period(period)
  );

  wuq_window_check #(
    .PER_W(PER_W)
  ) u_window (
    .period(period),
    .lim_lo(cfg_per_lo),
    .lim_hi(cfg_per_hi),
    .margin(cfg_hyst),
    .widen (acc_q != '0),
    .in_win(in_win),
    .eff_lo(win_lo),
    .eff_hi(win_hi)
  );

  wuq_watchdog #(
    .WD_W(WD_W)
  ) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (sensing),
    .reload(edge_ok),
    .limit (cfg_wd_limit),
    .expire(wd_expire)
  );

  assign sensing  = (state_q == WQ_SENSE);
  assign need_eff = clamp_need(cfg_need);
  assign edge_ok  = sensing && rise && in_win;
  assign edge_bad = sensing && rise && !in_win;
  assign run_done = edge_ok && run_complete(acc_q, need_eff);
  assign wd_trip  = sensing && wd_expire && !edge_ok;
  assign hib_wake = (state_q == WQ_HIB) && rise;
  assign clr_hit  = (state_q == WQ_AWAKE) && radio_clr;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WQ_HIB: begin
        if (hib_wake) state_d = WQ_SENSE;
      end
      WQ_SENSE: begin
        if (run_done)     state_d = WQ_AWAKE;
        else if (wd_trip) state_d = WQ_HIB;
      end
      WQ_AWAKE: begin
        if (clr_hit) state_d = WQ_HIB;
      end
      default: state_d = WQ_HIB;
    endcase
  end

  always_comb begin
    acc_d = acc_q;
    if (!sensing || edge_bad || run_done || wd_trip) begin
      acc_d = '0;
    end else if (edge_ok) begin
      acc_d = acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WQ_HIB;
      acc_q       <= '0;
      fault_pulse <= 1'b0;
    end else begin
      state_q     <= state_d;
      acc_q       <= acc_d;
      fault_pulse <= wd_trip;
    end
  end

  assign mode     = state_q;
  assign radio_en = (state_q == WQ_AWAKE);
  assign osc_cap  = cap_for(state_q, cfg_cap_hib, cfg_cap_sense, cfg_cap_awake);

  // R4
  radio_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(radio_en) |-> $past(edge_ok));

  // R9
  radio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (radio_en && !radio_clr) |=> radio_en);

  // R8
  fault_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  // R8
  fault_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> (mode == 2'd0 && !radio_en));

  // R7
  reject_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_bad |=> (acc_q == '0));

  // R10
  clr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sensing && radio_clr && !run_done && !wd_trip) |=> (mode == 2'd1));

endmodule

// File: tb/wuq_ctrl_tb.sv
`timescale 1ns/1ps
module wuq_ctrl_tb;

  localparam int PER_W = 12;
  localparam int CNT_W = 6;
  localparam int WD_W  = 16;
  localparam int CAP_W = 6;

  localparam logic [CAP_W-1:0] CAP_H = 6'h05;
  localparam logic [CAP_W-1:0] CAP_S = 6'h1A;
  localparam logic [CAP_W-1:0] CAP_A = 6'h33;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wake_in = 1'b0;
  logic [PER_W-1:0] cfg_per_lo = 12'd8;
  logic [PER_W-1:0] cfg_per_hi = 12'd12;
  logic [PER_W-1:0] cfg_hyst = 12'd2;
  logic [CNT_W-1:0] cfg_need = 6'd4;
  logic [WD_W-1:0]  cfg_wd_limit = 16'd200;
  logic [CAP_W-1:0] cfg_cap_hib = CAP_H;
  logic [CAP_W-1:0] cfg_cap_sense = CAP_S;
  logic [CAP_W-1:0] cfg_cap_awake = CAP_A;
  logic             radio_clr = 1'b0;
  logic             radio_en;
  logic [CAP_W-1:0] osc_cap;
  logic             fault_pulse;
  logic [1:0]       mode;

  int checks = 0;
  int fails = 0;
  int fault_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) if (fault_pulse) fault_seen++;

  wuq_ctrl #(
    .PER_W(PER_W), .CNT_W(CNT_W), .WD_W(WD_W), .CAP_W(CAP_W), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in),
    .cfg_per_lo(cfg_per_lo), .cfg_per_hi(cfg_per_hi), .cfg_hyst(cfg_hyst),
    .cfg_need(cfg_need), .cfg_wd_limit(cfg_wd_limit),
    .cfg_cap_hib(cfg_cap_hib), .cfg_cap_sense(cfg_cap_sense),
    .cfg_cap_awake(cfg_cap_awake), .radio_clr(radio_clr),
    .radio_en(radio_en), .osc_cap(osc_cap), .fault_pulse(fault_pulse), .mode(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // checks mode, enable and the oscillator code expected for that mode (R2)
  task automatic chk_mode(input string tag, input int exp_mode);
    int exp_cap;
    exp_cap = (exp_mode == 1) ? int'(CAP_S) : (exp_mode == 2) ? int'(CAP_A) : int'(CAP_H);
    chk({tag, " mode"}, int'(mode), exp_mode);
    chk({tag, " radio_en"}, int'(radio_en), (exp_mode == 2) ? 1 : 0);
    chk({tag, " osc_cap R2"}, int'(osc_cap), exp_cap);
  endtask

  task automatic do_reset(input int need, input int lo, input int hi, input int hy, input int wd);
    @(negedge clk);
    rst_n = 1'b0;
    wake_in = 1'b0;
    radio_clr = 1'b0;
    cfg_need = CNT_W'(need);
    cfg_per_lo = PER_W'(lo);
    cfg_per_hi = PER_W'(hi);
    cfg_hyst = PER_W'(hy);
    cfg_wd_limit = WD_W'(wd);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fault_seen = 0;
  endtask

  // one rising edge, then a gap of p cycles until the next call may rise
  task automatic cyc(input int p);
    wake_in = 1'b1;
    @(negedge clk);
    wake_in = 1'b0;
    repeat (p - 1) @(negedge clk);
  endtask

  task automatic clr_pulse();
    radio_clr = 1'b1;
    @(negedge clk);
    radio_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(4, 8, 12, 2, 200);
    chk_mode("R1 reset", 0);
    chk("R1 fault after reset", int'(fault_pulse), 0);
  endtask

  task automatic t_entry();
    do_reset(4, 8, 12, 2, 200);
    wake_in = 1'b1;
    @(negedge clk);
    chk("R3 entry after 1 edge", int'(mode), 0);
    @(negedge clk);
    chk("R3 entry after 2 edges", int'(mode), 0);
    wake_in = 1'b0;
    @(negedge clk);
    chk_mode("R3 entry after 3 edges", 1);
  endtask

  task automatic t_basic();
    do_reset(4, 8, 12, 2, 200);
    cyc(10);
    chk_mode("R3 sensing", 1);
    repeat (3) cyc(10);
    chk_mode("R4 three accepted", 1);
    cyc(10);
    chk_mode("R4 four accepted", 2);
    repeat (3) cyc(10);
    chk_mode("R9 hold through edges", 2);
    repeat (20) @(negedge clk);
    chk_mode("R9 hold idle", 2);
    clr_pulse();
    chk_mode("R9 cleared", 0);
  endtask

  task automatic t_base_window();
    do_reset(3, 8, 12, 2, 200);
    cyc(13); cyc(10); cyc(10); cyc(10);
    chk_mode("R5 13 rejected at count 0", 1);
    cyc(10);
    chk_mode("R5 run completes", 2);
  endtask

  task automatic t_hyst();
    do_reset(4, 8, 12, 2, 200);
    cyc(10); cyc(13); cyc(14); cyc(6); cyc(10);
    chk_mode("R6 widened window accepts 13,14,6", 2);
  endtask

  task automatic t_reject();
    do_reset(3, 8, 12, 2, 200);
    cyc(10); cyc(15); cyc(13); cyc(10); cyc(10); cyc(10);
    chk_mode("R7 15 then 13 rejected", 1);
    cyc(10);
    chk_mode("R7 run after restart", 2);
  endtask

  task automatic t_low();
    do_reset(2, 8, 12, 2, 200);
    cyc(10); cyc(5); cyc(10); cyc(10);
    chk_mode("R6 5 below widened floor", 1);
    cyc(10);
    chk_mode("R6 recovery", 2);
  endtask

  task automatic t_wd_timing();
    do_reset(4, 8, 12, 2, 30);
    wake_in = 1'b1;
    @(negedge clk);
    wake_in = 1'b0;
    repeat (32) @(negedge clk);
    chk("R8 sensing at limit+3", int'(mode), 1);
    chk("R8 no fault yet", int'(fault_pulse), 0);
    @(negedge clk);
    chk_mode("R8 hibernate at limit+4", 0);
    chk("R8 fault pulse", int'(fault_pulse), 1);
    @(negedge clk);
    chk("R8 fault one cycle", int'(fault_pulse), 0);
    chk("R8 fault count", fault_seen, 1);
  endtask

  task automatic t_wd_reload();
    do_reset(5, 20, 28, 2, 30);
    repeat (4) cyc(25);
    chk_mode("R8 accepted periods reload", 1);
    chk("R8 no fault while reloaded", fault_seen, 0);
    cyc(40);
    chk_mode("R8 expiry after stall", 0);
    chk("R8 one fault after stall", fault_seen, 1);
    do_reset(5, 20, 28, 2, 30);
    cyc(10); cyc(15); cyc(20);
    chk_mode("R8 rejected periods do not reload", 0);
    chk("R8 fault after rejects", fault_seen, 1);
  endtask

  task automatic t_clr_ignored();
    do_reset(4, 8, 12, 2, 200);
    clr_pulse();
    chk_mode("R10 clear in hibernate", 0);
    cyc(10);
    clr_pulse();
    chk_mode("R10 clear in sensing", 1);
    repeat (3) cyc(10);
    cyc(10);
    chk_mode("R10 run unaffected by clear", 2);
  endtask

  task automatic t_need_small();
    do_reset(1, 8, 12, 2, 200);
    cyc(10);
    chk_mode("R11 need 1 entry only", 1);
    cyc(10);
    chk_mode("R11 need 1 single period", 2);
    do_reset(0, 8, 12, 2, 200);
    cyc(10);
    chk_mode("R11 need 0 entry only", 1);
    cyc(10);
    chk_mode("R11 need 0 as 1", 2);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_basic();
    t_base_window();
    t_hyst();
    t_reject();
    t_low();
    t_wd_timing();
    t_wd_reload();
    t_clr_ignored();
    t_need_small();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule